// File: doc/BRIEF.md
# Privilege and Banked Stack Control

This block keeps the processor's execution context: whether code runs in thread or handler mode, whether thread code is privileged, and which of two stack pointers (main or process) is live. A two-bit control word holds an unprivileged flag and a process-stack select. Handler mode overrides both fields. Software sees exactly one stack pointer through a single read/write port, and that port always addresses the bank currently selected.

Exception entry and return arrive as single-cycle strobes. A nesting counter tracks how deep the handler chain is. Thread mode resumes only when the counter returns to zero, and at that point the stack bank follows the control word again. Each bank has its own lower limit register. A stack write below the active limit is refused and flagged for one cycle. Control or limit writes that the current state does not permit are dropped, and a one-cycle ignored-write flag is raised.

Top module: `privStackCtl`

## Requirements
- R1: While reset is asserted and on release, the block is in thread mode (`inHandler`=0), privileged (`isPriv`=1), on the main bank (`useProcess`=0), with `ctlRdData`=00, both limits 0, both flags low, and the main stack pointer loaded from `resetVector`. The process stack pointer has no defined reset value.
- R2: `ctlRdData[0]`=1 makes thread mode unprivileged and 0 makes it privileged. Handler mode is privileged whatever bit 0 holds.
- R3: `ctlRdData[1]`=1 selects the process bank in thread mode and 0 selects the main bank. In handler mode the main bank is used whatever bit 1 holds. `spRdData` always shows the selected bank.
- R4: A control write (`ctlWrEn`, `ctlWrData`) changes bit 0 only while privileged. An unprivileged thread cannot return itself to privileged, and only a handler clearing bit 0 restores it.
- R5: Control bit 1 changes only in privileged thread mode. A control write in handler mode updates bit 0 and leaves bit 1 as it was.
- R6: A stack write (`spWrEn`) updates only the currently selected bank. The other bank is left unchanged. The new value appears on `spRdData` one clock edge after the write is sampled.
- R7: A stack write whose value is below the active bank's limit (unsigned compare) is dropped, and `stackOverflow` is high for the one cycle after it. A value equal to the limit is accepted. Back-to-back offending writes give one pulse per write.
- R8: A limit write goes to the main limit when `limWrSel`=0 and to the process limit when `limWrSel`=1. It is ignored while unprivileged.
- R9: `excEnter` enters handler mode and increments the nesting depth, which saturates at 2^NEST_W-1. `excReturn` decrements a nonzero depth and reaches thread mode at zero, where the bank choice again follows bit 1. A return at depth zero has no effect. Entry and return in the same cycle leave the depth unchanged.
- R10: `writeIgnored` is high for the one cycle after any control write in handler mode or unprivileged thread mode, and after any limit write while unprivileged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resetVector | input | SP_W | Main stack pointer reset value |
| excEnter | input | 1 | Exception entry strobe |
| excReturn | input | 1 | Exception return strobe |
| ctlWrEn | input | 1 | Control word write request |
| ctlWrData | input | 2 | Control value: bit0 unprivileged, bit1 process select |
| spWrEn | input | 1 | Write request to the visible stack pointer |
| spWrData | input | SP_W | Stack pointer write value |
| limWrEn | input | 1 | Limit register write request |
| limWrSel | input | 1 | Limit target: 0 main, 1 process |
| limWrData | input | SP_W | Limit write value |
| spRdData | output | SP_W | Value of the selected stack pointer |
| ctlRdData | output | 2 | Stored control word |
| isPriv | output | 1 | Current code is privileged |
| inHandler | output | 1 | Handler mode active |
| useProcess | output | 1 | Process bank currently selected |
| stackOverflow | output | 1 | One-cycle flag: stack write refused by limit |
| writeIgnored | output | 1 | One-cycle flag: disallowed write dropped |

## Verification
The bench targets the places where the permission rules and mode overrides meet. It writes the control word from handler mode, where a design that gated bit 1 incorrectly would change the thread-mode bank selection on return. It has an unprivileged thread try to regain privilege and to move a limit; a leaky gate would show up as a changed privilege or as a later stack write that is accepted or refused wrongly. Nesting is driven to saturation and unwound, with an entry and a return in the same cycle, so that a counter that wraps or miscounts returns to thread mode at the wrong time. Writes exactly at the limit and one below it catch an off-by-one compare, and a write that lands in the wrong bank shows up when the bench switches banks.

// File: rtl/privStackPkg.sv
package privStackPkg;
  // Strobes from control to datapath, already qualified by permission.
  typedef struct packed {
    logic       spWr;     // stack write request to the selected bank
    logic       selProc;  // 1: process bank is the selected bank
    logic [1:0] limWr;    // per-bank limit write, index 0 main, 1 process
  } dpStrobes_t;

  localparam int BANK_MAIN = 0;
  localparam int BANK_PROC = 1;
  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/privStackCtrl.sv
module privStackCtrl
  import privStackPkg::*;
#(
  parameter int NEST_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       excEnter,
  input  logic       excReturn,
  input  logic       ctlWrEn,
  input  logic [1:0] ctlWrData,
  input  logic       spWrEn,
  input  logic       limWrEn,
  input  logic       limWrSel,
  output dpStrobes_t strb,
  output logic [1:0] ctlBits,
  output logic       isPriv,
  output logic       inHandler,
  output logic       useProcess,
  output logic       writeIgnored
);
  localparam logic [NEST_W-1:0] DEPTH_MAX  = '1;
  localparam logic [NEST_W-1:0] DEPTH_ZERO = '0;
  localparam logic [NEST_W-1:0] DEPTH_ONE  = NEST_W'(1);

  logic [NEST_W-1:0] depth;
  logic              ctlUnpriv;
  logic              ctlProcSel;
  logic              canWrPriv;
  logic              canWrSel;
  logic              enterOnly;
  logic              returnOnly;
  logic              ignoreNext;

  always_comb begin
    inHandler  = (depth != DEPTH_ZERO);
    isPriv     = inHandler || !ctlUnpriv;
    useProcess = !inHandler && ctlProcSel;
    canWrPriv  = isPriv;
    canWrSel   = isPriv && !inHandler;
    enterOnly  = excEnter && !excReturn;
    returnOnly = excReturn && !excEnter;
    ignoreNext = (ctlWrEn && !canWrSel) || (limWrEn && !isPriv);
    ctlBits    = {ctlProcSel, ctlUnpriv};
  end

  always_comb begin
    strb.spWr    = spWrEn;
    strb.selProc = useProcess;
    strb.limWr   = '0;
    strb.limWr[BANK_MAIN] = limWrEn && isPriv && !limWrSel;
    strb.limWr[BANK_PROC] = limWrEn && isPriv &&  limWrSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth        <= DEPTH_ZERO;
      ctlUnpriv    <= 1'b0;
      ctlProcSel   <= 1'b0;
      writeIgnored <= 1'b0;
    end else begin
      if (enterOnly && depth != DEPTH_MAX) begin
        depth <= depth + DEPTH_ONE;
      end else if (returnOnly && depth != DEPTH_ZERO) begin
        depth <= depth - DEPTH_ONE;
      end
      if (ctlWrEn && canWrPriv) ctlUnpriv  <= ctlWrData[0];
      if (ctlWrEn && canWrSel)  ctlProcSel <= ctlWrData[1];
      writeIgnored <= ignoreNext;
    end
  end
endmodule

// File: rtl/privStackDatapath.sv
module privStackDatapath
  import privStackPkg::*;
#(
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SP_W-1:0] resetVector,
  input  dpStrobes_t      strb,
  input  logic [SP_W-1:0] spWrData,
  input  logic [SP_W-1:0] limWrData,
  output logic [SP_W-1:0] spRdData,
  output logic            stackOverflow
);
  logic [SP_W-1:0] mainSp;
  logic [SP_W-1:0] procSp;
  logic [SP_W-1:0] limBank [NUM_BANKS];
  logic [SP_W-1:0] activeLimit;
  logic            belowLimit;
  logic            storeOk;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_limit
    always_ff @(posedge clk) begin
      if (!rstN)             limBank[b] <= '0;
      else if (strb.limWr[b]) limBank[b] <= limWrData;
    end
  end

  always_comb begin
    activeLimit = strb.selProc ? limBank[BANK_PROC] : limBank[BANK_MAIN];
    belowLimit  = spWrData < activeLimit;
    storeOk     = strb.spWr && !belowLimit;
    spRdData    = strb.selProc ? procSp : mainSp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainSp        <= resetVector;
      stackOverflow <= 1'b0;
    end else begin
      if (storeOk && !strb.selProc) mainSp <= spWrData;
      stackOverflow <= strb.spWr && belowLimit;
    end
  end

  // Process bank carries no reset value.
  always_ff @(posedge clk) begin
    if (rstN && storeOk && strb.selProc) procSp <= spWrData;
  end
endmodule

// File: rtl/privStackCtl.sv
module privStackCtl
  import privStackPkg::*;
#(
  parameter int SP_W   = 32,
  parameter int NEST_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SP_W-1:0] resetVector,
  input  logic            excEnter,
  input  logic            excReturn,
  input  logic            ctlWrEn,
  input  logic [1:0]      ctlWrData,
  input  logic            spWrEn,
  input  logic [SP_W-1:0] spWrData,
  input  logic            limWrEn,
  input  logic            limWrSel,
  input  logic [SP_W-1:0] limWrData,
  output logic [SP_W-1:0] spRdData,
  output logic [1:0]      ctlRdData,
  output logic            isPriv,
  output logic            inHandler,
  output logic            useProcess,
  output logic            stackOverflow,
  output logic            writeIgnored
);
  dpStrobes_t strb;

  privStackCtrl #(.NEST_W(NEST_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .excEnter(excEnter), .excReturn(excReturn),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .spWrEn(spWrEn), .limWrEn(limWrEn), .limWrSel(limWrSel),
    .strb(strb), .ctlBits(ctlRdData),
    .isPriv(isPriv), .inHandler(inHandler), .useProcess(useProcess),
    .writeIgnored(writeIgnored)
  );

  privStackDatapath #(.SP_W(SP_W)) u_dp (
    .clk(clk), .rstN(rstN), .resetVector(resetVector),
    .strb(strb), .spWrData(spWrData), .limWrData(limWrData),
    .spRdData(spRdData), .stackOverflow(stackOverflow)
  );
endmodule

// File: rtl/privStackChk.sv
module privStackChk (
  input logic       clk,
  input logic       rstN,
  input logic       excEnter,
  input logic       excReturn,
  input logic       ctlWrEn,
  input logic       spWrEn,
  input logic       limWrEn,
  input logic [1:0] ctlRdData,
  input logic       isPriv,
  input logic       inHandler,
  input logic       useProcess,
  input logic       stackOverflow,
  input logic       writeIgnored
);
  a_r3_handler_main: assert property (@(posedge clk) disable iff (!rstN)
    inHandler |-> !useProcess);

  a_r4_unpriv_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!isPriv && !excEnter) |=> !isPriv);

  a_r5_sel_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(inHandler) |-> (ctlRdData[1] == $past(ctlRdData[1])));

  a_r9_enter_handler: assert property (@(posedge clk) disable iff (!rstN)
    (excEnter && !excReturn) |=> inHandler);

  a_r9_return_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inHandler) |-> $past(excReturn));

  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    stackOverflow |-> $past(spWrEn));

  a_r10_ign_cause: assert property (@(posedge clk) disable iff (!rstN)
    writeIgnored |-> $past(ctlWrEn || limWrEn));
endmodule

bind privStackCtl privStackChk u_chk (
  .clk(clk), .rstN(rstN), .excEnter(excEnter), .excReturn(excReturn),
  .ctlWrEn(ctlWrEn), .spWrEn(spWrEn), .limWrEn(limWrEn),
  .ctlRdData(ctlRdData), .isPriv(isPriv), .inHandler(inHandler),
  .useProcess(useProcess), .stackOverflow(stackOverflow),
  .writeIgnored(writeIgnored)
);

// File: tb/privStackCtl_bench.sv
module privStackCtl_bench;
  localparam int SP_W   = 32;
  localparam int NEST_W = 3;
  localparam int MAXD   = (1 << NEST_W) - 1;
  localparam logic [31:0] RV = 32'h2000_1000;

  logic            clk = 1'b0;
  logic            rstN;
  logic [SP_W-1:0] resetVector;
  logic            excEnter, excReturn, ctlWrEn, spWrEn, limWrEn, limWrSel;
  logic [1:0]      ctlWrData;
  logic [SP_W-1:0] spWrData, limWrData;
  logic [SP_W-1:0] spRdData;
  logic [1:0]      ctlRdData;
  logic            isPriv, inHandler, useProcess, stackOverflow, writeIgnored;

  always #10 clk = ~clk;

  privStackCtl #(.SP_W(SP_W), .NEST_W(NEST_W)) u_privStackCtl (.*);

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string curReq = "R1";

  // Behavioural reference state
  int          mDepth;
  bit          mC0, mC1, mPspKnown, mOvf, mIgn;
  logic [31:0] mMsp, mPsp, mLimM, mLimP;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit hand, priv, useP;
    hand = (mDepth != 0);
    priv = hand || !mC0;
    useP = !hand && mC1;
    chk(32'(inHandler), 32'(hand), "inHandler");
    chk(32'(isPriv), 32'(priv), "isPriv");
    chk(32'(useProcess), 32'(useP), "useProcess");
    chk(32'(ctlRdData), 32'({mC1, mC0}), "ctlRdData");
    chk(32'(stackOverflow), 32'(mOvf), "stackOverflow");
    chk(32'(writeIgnored), 32'(mIgn), "writeIgnored");
    if (!useP) chk(spRdData, mMsp, "spRdData main");
    else if (mPspKnown) chk(spRdData, mPsp, "spRdData process");
  endtask

  task automatic modelStep();
    bit hand, priv, useP, nIgn, nOvf;
    logic [31:0] lim;
    hand = (mDepth != 0);
    priv = hand || !mC0;
    useP = !hand && mC1;
    lim  = useP ? mLimP : mLimM;
    nIgn = 0;
    nOvf = spWrEn && (spWrData < lim);
    if (spWrEn && !nOvf) begin
      if (useP) begin mPsp = spWrData; mPspKnown = 1; end
      else mMsp = spWrData;
    end
    if (ctlWrEn) begin
      if (priv) mC0 = ctlWrData[0];
      if (priv && !hand) mC1 = ctlWrData[1];
      else nIgn = 1;
    end
    if (limWrEn) begin
      if (priv) begin
        if (limWrSel) mLimP = limWrData; else mLimM = limWrData;
      end else nIgn = 1;
    end
    if (excEnter && !excReturn) begin
      if (mDepth < MAXD) mDepth++;
    end else if (excReturn && !excEnter && mDepth > 0) begin
      mDepth--;
    end
    mOvf = nOvf;
    mIgn = nIgn;
  endtask

  task automatic clearIn();
    excEnter = 0; excReturn = 0; ctlWrEn = 0; spWrEn = 0; limWrEn = 0;
    limWrSel = 0; ctlWrData = '0; spWrData = '0; limWrData = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    clearIn();
    compareAll();
  endtask

  task automatic doCtl(input logic [1:0] d);
    ctlWrEn = 1; ctlWrData = d; cyc();
  endtask
  task automatic doSp(input logic [31:0] v);
    spWrEn = 1; spWrData = v; cyc();
  endtask
  task automatic doLim(input logic s, input logic [31:0] v);
    limWrEn = 1; limWrSel = s; limWrData = v; cyc();
  endtask
  task automatic doEnter(); excEnter = 1; cyc(); endtask
  task automatic doReturn(); excReturn = 1; cyc(); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearIn();
    rstN = 0;
    resetVector = RV;
    repeat (3) @(negedge clk);
    rstN = 1;
    mDepth = 0; mC0 = 0; mC1 = 0; mPspKnown = 0; mOvf = 0; mIgn = 0;
    mMsp = RV; mPsp = '0; mLimM = '0; mLimP = '0;
    curReq = "R1";
    compareAll();
    cyc();

    curReq = "R6"; doSp(32'h2000_0F00);
    curReq = "R8"; doLim(1'b0, 32'h2000_0800);
    curReq = "R7"; doSp(32'h2000_07FF);
    doSp(32'h2000_0800);
    doSp(32'h0000_0010); doSp(32'h0000_0020);
    cyc();

    curReq = "R3"; doCtl(2'b10);
    doSp(32'h1000_0400);
    curReq = "R8"; doLim(1'b1, 32'h1000_0100);
    curReq = "R7"; doSp(32'h1000_00FF);
    doSp(32'h1000_0100);

    curReq = "R2"; doCtl(2'b11);
    curReq = "R4"; doCtl(2'b00);
    curReq = "R10"; doCtl(2'b10);
    curReq = "R8"; doLim(1'b1, 32'h1000_0300);
    doSp(32'h1000_0200);

    curReq = "R9"; doEnter();
    curReq = "R5"; doCtl(2'b00);
    curReq = "R6"; doSp(32'h2000_0C00);
    curReq = "R9"; doEnter();
    excEnter = 1; excReturn = 1; cyc();
    doReturn();
    doReturn();
    cyc();
    curReq = "R3"; doSp(32'h1000_0500);
    curReq = "R9"; doReturn();
    for (int i = 0; i < MAXD + 2; i++) doEnter();
    for (int i = 0; i < MAXD - 1; i++) doReturn();
    doReturn();
    doReturn();

    curReq = "R5"; doCtl(2'b01);
    curReq = "R4"; doEnter();
    doCtl(2'b01);
    doReturn();
    doCtl(2'b00);
    cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule